// File: doc/BRIEF.md
# Saturating Dual Event Counter

This block counts cache activity for performance analysis. Two identical 32-bit counters share one global enable bit. Each counter has its own configuration register, which picks one of fifteen event strobes coming from the cache. A source code of zero parks the counter. The configuration register also holds an interrupt-disable flag that software writes together with the source code.

A counter that reaches all-ones stays there and never wraps. Software therefore reads the counters often enough, and between reads it reloads them with zero while counting is globally stopped. All registers sit behind a plain single-cycle port: a write strobe with address and data, and a read data bus that follows the address combinationally. The per-counter registers are placed in pairs in descending order, so counter 1 always sits one word below counter 0.

Top module: `evc_unit`

## Requirements
- R1: With the global enable set, a counter whose configured source code k is non-zero increments by exactly one on each clock edge at which `evt_strobe[k]` is high, and otherwise keeps its value.
- R2: A counter holding 0xFFFFFFFF keeps that value on further selected events and never wraps to zero.
- R3: Word addresses are: control 0x00, counter 1 config 0x04, counter 0 config 0x08, counter 1 value 0x0C, counter 0 value 0x10. The counter 1 register of each pair lies 4 bytes below the counter 0 register.
- R4: While control bit 0 (global enable) is clear, neither counter changes except by a software write, whatever its configuration.
- R5: Source code 0 stops the counter. Each counter follows only the strobe bit that its own code selects.
- R6: The config register holds the source code in bits [5:2] and the interrupt-disable flag in bit 0. The control register holds the enable in bit 0. All other bits of both registers read as zero.
- R7: A write to a value register loads the written 32-bit data. If a selected event arrives in the same cycle, the written value is kept and the event is lost.
- R8: After reset both counters read zero, both source codes are 0, both flags are clear and the global enable is clear.
- R9: A read of any unmapped address returns zero. A write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_strobe | input | 16 | Event strobes from the cache; bit k is source code k, bit 0 is unused |

## Verification
The bench builds the block with its default parameters: two counters of 32 bits and a 4-bit source field over 16 strobes. Full-width counters can only reach saturation in a short run if they are preloaded, so the bench writes values a few counts below all-ones. The random phase also writes values near the top of the range and then runs selected events across the ceiling. Every source code can be drawn, including 0 and codes whose strobe is held low. This exercises the parked state, the shared-strobe case and the write-versus-event collision.

// File: rtl/evc_pkg.sv
package evc_pkg;
    // field layout of the registers
    localparam int unsigned SRC_W       = 4;
    localparam int unsigned SRC_LSB     = 2;
    localparam int unsigned IRQ_DIS_BIT = 0;
    localparam int unsigned CTRL_EN_BIT = 0;
    localparam int unsigned EVT_W       = 1 << SRC_W;
    localparam int unsigned WORD_BYTES  = 4;

    typedef logic [SRC_W-1:0] src_t;

    typedef struct packed {
        src_t src;
        logic irq_dis;
    } cfg_t;

    localparam src_t SRC_OFF = '0;
endpackage

// File: rtl/evc_decode.sv
module evc_decode #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_CNT  = 2,
    parameter int unsigned CTRL_OFS = 0,
    parameter int unsigned CFG_BASE = 4,
    parameter int unsigned VAL_BASE = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               ctrl_hit,
    output logic [NUM_CNT-1:0] cfg_hit,
    output logic [NUM_CNT-1:0] val_hit
);
    import evc_pkg::*;

    // Pairs are placed in descending order: the highest-numbered counter
    // takes the lowest address of each group.
    always_comb begin
        ctrl_hit = (addr == ADDR_W'(CTRL_OFS));
        for (int i = 0; i < int'(NUM_CNT); i++) begin
            cfg_hit[i] = (addr == ADDR_W'(CFG_BASE + WORD_BYTES * (NUM_CNT - 1 - i)));
            val_hit[i] = (addr == ADDR_W'(VAL_BASE + WORD_BYTES * (NUM_CNT - 1 - i)));
        end
    end
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     glb_en,
    input  logic [evc_pkg::EVT_W-1:0] evt,
    input  logic                     cfg_we,
    input  logic                     val_we,
    input  logic [DATA_W-1:0]        wdata,
    output evc_pkg::cfg_t            cfg_o,
    output logic [CNT_W-1:0]         val_o
);
    import evc_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        cfg_t             cfg;
        logic [CNT_W-1:0] val;
    } state_t;

    state_t s_d, s_q;
    logic   hit;

    always_comb begin
        s_d = s_q;
        hit = glb_en && (s_q.cfg.src != SRC_OFF) && evt[s_q.cfg.src];

        // saturating step
        if (hit && (s_q.val != CNT_MAX)) begin
            s_d.val = s_q.val + CNT_W'(1);
        end

        // software load overrides a same-cycle event
        if (val_we) begin
            s_d.val = wdata[CNT_W-1:0];
        end

        if (cfg_we) begin
            s_d.cfg.src     = wdata[SRC_LSB +: SRC_W];
            s_d.cfg.irq_dis = wdata[IRQ_DIS_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cfg.src     <= SRC_OFF;
            s_q.cfg.irq_dis <= 1'b0;
            s_q.val         <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o = s_q.cfg;
    assign val_o = s_q.val;
endmodule

// File: rtl/evc_rdmux.sv
module evc_rdmux #(
    parameter int unsigned NUM_CNT = 2,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                              ctrl_hit,
    input  logic [NUM_CNT-1:0]                cfg_hit,
    input  logic [NUM_CNT-1:0]                val_hit,
    input  logic                              glb_en,
    input  logic [NUM_CNT-1:0][evc_pkg::SRC_W-1:0] src,
    input  logic [NUM_CNT-1:0]                irq_dis,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]     val,
    output logic [DATA_W-1:0]                 rdata
);
    import evc_pkg::*;

    // decode hits are one-hot, so an OR tree is sufficient
    always_comb begin
        rdata = '0;
        if (ctrl_hit) begin
            rdata[CTRL_EN_BIT] = glb_en;
        end
        for (int i = 0; i < int'(NUM_CNT); i++) begin
            if (cfg_hit[i]) begin
                rdata[SRC_LSB +: SRC_W] = rdata[SRC_LSB +: SRC_W] | src[i];
                rdata[IRQ_DIS_BIT]      = rdata[IRQ_DIS_BIT] | irq_dis[i];
            end
            if (val_hit[i]) begin
                rdata = rdata | DATA_W'(val[i]);
            end
        end
    end
endmodule

// File: rtl/evc_unit.sv
module evc_unit #(
    parameter int unsigned NUM_CNT = 2,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [evc_pkg::EVT_W-1:0] evt_strobe
);
    import evc_pkg::*;

    localparam int unsigned CTRL_OFS = 0;
    localparam int unsigned CFG_BASE = CTRL_OFS + WORD_BYTES;
    localparam int unsigned VAL_BASE = CFG_BASE + WORD_BYTES * NUM_CNT;

    typedef struct packed {
        logic en;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic               ctrl_hit;
    logic [NUM_CNT-1:0] cfg_hit, val_hit;
    logic [NUM_CNT-1:0] cfg_we, val_we;

    logic [NUM_CNT-1:0][SRC_W-1:0] cnt_src;
    logic [NUM_CNT-1:0]            cnt_irq_dis;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;

    evc_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_CNT (NUM_CNT),
        .CTRL_OFS(CTRL_OFS),
        .CFG_BASE(CFG_BASE),
        .VAL_BASE(VAL_BASE)
    ) u_decode (
        .addr    (bus_addr),
        .ctrl_hit(ctrl_hit),
        .cfg_hit (cfg_hit),
        .val_hit (val_hit)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        cfg_we = cfg_hit & {NUM_CNT{bus_wr}};
        val_we = val_hit & {NUM_CNT{bus_wr}};
        if (bus_wr && ctrl_hit) begin
            ctrl_d.en = bus_wdata[CTRL_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.en <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    for (genvar g = 0; g < int'(NUM_CNT); g++) begin : g_cnt
        cfg_t cfg_w;

        evc_counter #(
            .CNT_W (CNT_W),
            .DATA_W(DATA_W)
        ) u_counter (
            .clk   (clk),
            .rst_n (rst_n),
            .glb_en(ctrl_q.en),
            .evt   (evt_strobe),
            .cfg_we(cfg_we[g]),
            .val_we(val_we[g]),
            .wdata (bus_wdata),
            .cfg_o (cfg_w),
            .val_o (cnt_val[g])
        );

        assign cnt_src[g]     = cfg_w.src;
        assign cnt_irq_dis[g] = cfg_w.irq_dis;
    end

    evc_rdmux #(
        .NUM_CNT(NUM_CNT),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_rdmux (
        .ctrl_hit(ctrl_hit),
        .cfg_hit (cfg_hit),
        .val_hit (val_hit),
        .glb_en  (ctrl_q.en),
        .src     (cnt_src),
        .irq_dis (cnt_irq_dis),
        .val     (cnt_val),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/evc_chk.sv
module evc_chk #(
    parameter int unsigned NUM_CNT = 2,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned DATA_W  = 32
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   glb_en,
    input logic [NUM_CNT-1:0]                     val_we,
    input logic [DATA_W-1:0]                      wdata,
    input logic [NUM_CNT-1:0][evc_pkg::SRC_W-1:0] src,
    input logic [NUM_CNT-1:0][CNT_W-1:0]          val
);
    for (genvar g = 0; g < int'(NUM_CNT); g++) begin : g_prop
        // R1: at most one step per clock
        p_single_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !val_we[g] |=> (val[g] == $past(val[g])) || (val[g] == $past(val[g]) + CNT_W'(1)));

        // R2: all-ones is sticky
        p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!val_we[g] && (val[g] == {CNT_W{1'b1}})) |=> (val[g] == {CNT_W{1'b1}}));

        // R4: frozen while globally disabled
        p_frozen_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!val_we[g] && !glb_en) |=> $stable(val[g]));

        // R5: parked source does not count
        p_parked_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!val_we[g] && (src[g] == '0)) |=> $stable(val[g]));

        // R7: software load takes priority
        p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            val_we[g] |=> (val[g] == $past(wdata[CNT_W-1:0])));
    end
endmodule

bind evc_unit evc_chk #(
    .NUM_CNT(NUM_CNT),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .glb_en(ctrl_q.en),
    .val_we(val_we),
    .wdata (bus_wdata),
    .src   (cnt_src),
    .val   (cnt_val)
);

// File: tb/evc_unit_tb.sv
`timescale 1ns/100ps
module evc_unit_tb;
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_CFG1 = 8'h04;
    localparam logic [7:0] A_CFG0 = 8'h08;
    localparam logic [7:0] A_VAL1 = 8'h0C;
    localparam logic [7:0] A_VAL0 = 8'h10;
    localparam logic [7:0] A_HOLE = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] evt_strobe = '0;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_val [2];
    logic [3:0]  m_src [2];
    logic        m_idis[2];
    logic        m_en;

    always #5 clk = ~clk;

    evc_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_strobe(evt_strobe)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            A_CTRL:  return {31'd0, m_en};
            A_CFG0:  return {26'd0, m_src[0], 1'b0, m_idis[0]};
            A_CFG1:  return {26'd0, m_src[1], 1'b0, m_idis[1]};
            A_VAL0:  return m_val[0];
            A_VAL1:  return m_val[1];
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] sat_next(input logic [31:0] v, input logic en,
                                             input logic [3:0] s, input logic [15:0] e);
        if (en && s != 4'd0 && e[s] && v != 32'hFFFF_FFFF) return v + 32'd1;
        return v;
    endfunction

    task automatic model_step(input logic wr, input logic [7:0] a,
                              input logic [31:0] d, input logic [15:0] e);
        logic [31:0] nv0, nv1;
        nv0 = sat_next(m_val[0], m_en, m_src[0], e);
        nv1 = sat_next(m_val[1], m_en, m_src[1], e);
        if (wr) begin
            case (a)
                A_CTRL: m_en = d[0];
                A_CFG0: begin m_src[0] = d[5:2]; m_idis[0] = d[0]; end
                A_CFG1: begin m_src[1] = d[5:2]; m_idis[1] = d[0]; end
                A_VAL0: nv0 = d;
                A_VAL1: nv1 = d;
                default: ;
            endcase
        end
        m_val[0] = nv0;
        m_val[1] = nv1;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic tick(input logic wr, input logic [7:0] a,
                        input logic [31:0] d, input logic [15:0] e);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_strobe = e;
        @(posedge clk);
        model_step(wr, a, d, e);
        @(negedge clk);
        bus_wr = 1'b0; evt_strobe = '0;
    endtask

    task automatic chk_reg(input logic [7:0] a, input string tag);
        logic [31:0] exp;
        bus_wr = 1'b0; evt_strobe = '0; bus_addr = a;
        #0.6;
        exp = exp_read(a);
        n_vec++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag, a, bus_rdata, exp);
        end
    endtask

    // idle edge afterwards: no writes and no strobes, so the model is unchanged
    task automatic chk_all(input string tag);
        chk_reg(A_CTRL, tag);
        chk_reg(A_CFG1, tag);
        chk_reg(A_CFG0, tag);
        chk_reg(A_VAL1, tag);
        chk_reg(A_VAL0, tag);
        chk_reg(A_HOLE, tag);
        @(negedge clk);
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] amap[7];
        void'($urandom(32'h5EED_0C11));
        amap = '{A_CTRL, A_CFG1, A_CFG0, A_VAL1, A_VAL0, A_HOLE, 8'h20};
        for (int i = 0; i < 2; i++) begin
            m_val[i] = '0; m_src[i] = '0; m_idis[i] = 1'b0;
        end
        m_en = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R8 reset state");
        chk_reg(8'h3C, "R9 unmapped read");
        @(negedge clk);

        // R6: field packing and unused bits
        tick(1'b1, A_CFG0, 32'hFFFF_FFFF, '0);
        chk_all("R6 cfg all ones");
        tick(1'b1, A_CTRL, 32'hFFFF_FFFE, '0);
        chk_all("R6 ctrl unused bits");

        // R3/R5: counter 0 on code 2, counter 1 on code 7
        tick(1'b1, A_CFG0, 32'h0000_0008, '0);
        tick(1'b1, A_CFG1, 32'h0000_001D, '0);
        tick(1'b1, A_VAL0, 32'h0, '0);
        tick(1'b1, A_VAL1, 32'h0, '0);
        // R4: disabled globally
        for (int k = 0; k < 3; k++) tick(1'b0, A_CTRL, '0, 16'hFFFF);
        chk_all("R4 global enable clear");

        tick(1'b1, A_CTRL, 32'h1, '0);
        for (int k = 0; k < 4; k++) tick(1'b0, A_CTRL, '0, 16'h0004);
        chk_all("R1 R3 counter 0 only");
        for (int k = 0; k < 3; k++) tick(1'b0, A_CTRL, '0, 16'hFFFF);
        chk_all("R1 both counting");
        for (int k = 0; k < 2; k++) tick(1'b0, A_CTRL, '0, 16'h0080);
        chk_all("R3 R5 counter 1 only");

        // R5: parked source
        tick(1'b1, A_CFG1, 32'h0, '0);
        for (int k = 0; k < 3; k++) tick(1'b0, A_CTRL, '0, 16'hFFFF);
        chk_all("R5 source zero");

        // R7: write collides with event
        tick(1'b1, A_VAL0, 32'h1234_5678, 16'h0004);
        chk_all("R7 write beats event");

        // R2: saturation
        tick(1'b1, A_VAL0, 32'hFFFF_FFFD, '0);
        for (int k = 0; k < 5; k++) tick(1'b0, A_CTRL, '0, 16'h0004);
        chk_all("R2 saturate");

        // R9: writes to holes
        tick(1'b1, A_HOLE, 32'hFFFF_FFFF, '0);
        tick(1'b1, 8'h40, 32'hFFFF_FFFF, '0);
        chk_all("R9 unmapped write");

        // random phase
        for (int n = 0; n < 600; n++) begin
            logic        wr;
            logic [7:0]  a;
            logic [31:0] d;
            wr = ($urandom_range(0, 9) < 3);
            a  = amap[$urandom_range(0, 6)];
            d  = $urandom();
            if ((a == A_VAL0 || a == A_VAL1) && $urandom_range(0, 1) == 1)
                d = 32'hFFFF_FFF0 + 32'($urandom_range(0, 15));
            if (a == A_CFG0 || a == A_CFG1)
                d = {26'($urandom()), 4'($urandom()), 2'($urandom())};
            tick(wr, a, d, 16'($urandom()));
            if ((n % 4) == 3) chk_all("R1 R2 R7 random");
        end
        chk_all("R1 R2 random final");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule